// File: doc/BRIEF.md
# Configurable Two-Plane Sum-of-Products Array

This block computes a set of Boolean outputs as sums of products over its inputs. Both planes can be programmed. Every input is split into a true rail and an inverted rail. A programmable AND plane builds each product-term row from any subset of those rails. A programmable OR plane then chooses which rows feed each output. Any row may feed any number of outputs. The path from `in_vec` to `out_vec` is purely combinational, so an output follows its inputs within the same cycle, with no clock edge in between.

The configuration is loaded serially. One bit enters a shadow chain on each clock edge that sees the shift enable high. The planes in use are updated only when a load strobe copies the whole shadow chain across. A partly shifted pattern therefore never reaches the outputs. After reset, both the shadow chain and the active planes are all zero.

The configuration word is `CFG_LEN = N_TERM*2*N_IN + N_OUT*N_TERM` bits long. The AND-plane field occupies the upper bits and the OR-plane field the lower bits. The loader decodes each cycle into one of four actions: idle, shift, load, or shift-and-load.

Top module: `pla_array`

## Requirements
- R1: Rail `2*i` of every row is input `i` as applied. Rail `2*i+1` is its inverse. A row that selects only one rail equals that rail.
- R2: A row equals the AND of the rails it selects. A row that selects no rail equals 1.
- R3: A row that selects both rails of the same input is always 0.
- R4: An output equals the OR of the rows selected for it. An output with no row selected is 0.
- R5: One row selected for several outputs drives all of them at the same time.
- R6: With A=in[0], B=in[1] and C=in[2], row 0 = A·B, row 1 = A·C, and both rows ORed into out[0], out[0] equals AB + AC for every input value.
- R7: Configuration bits enter MSB-first. After CFG_LEN shifts, the first bit sent sits at word bit CFG_LEN-1. The AND bit for row p, rail r is word bit `N_OUT*N_TERM + p*2*N_IN + r`. The OR bit for output m, row p is word bit `m*N_TERM + p`.
- R8: Shifting without a load leaves the outputs unchanged.
- R9: A load strobe copies the shadow chain into the active planes at the edge where it is sampled. From then on, the outputs follow the new pattern.
- R10: When shift and load are high at the same edge, the planes receive the shadow contents from before that edge, and the shift still takes place.
- R11: Reset clears the shadow chain and the active planes. Outputs are 0, and a load with no shifting keeps them 0.
- R12: The outputs respond to input changes combinationally, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration loader |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_shift_en | input | 1 | Shift `cfg_bit` into the shadow chain |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_load | input | 1 | Copy the shadow chain to the active planes |
| in_vec | input | N_IN | Logic inputs |
| out_vec | output | N_OUT | Sum-of-products outputs |

## Verification
The one pair of functions that can land in the same cycle is a shift and a load. The bench provokes this in a directed step. It first fills the shadow chain with a complete pattern while another pattern is active. In a single cycle it then raises `cfg_load` together with `cfg_shift_en`. The outputs are judged against a model built from the pre-shift pattern. A second plain load then shows that the extra bit was still shifted in, because the outputs must then match the pattern shifted by one position.

// File: rtl/pla_pkg.sv
package pla_pkg;

    // Action taken by the configuration loader in one cycle: {load, shift}
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'b00,
        ACT_SHIFT = 2'b01,
        ACT_LOAD  = 2'b10,
        ACT_BOTH  = 2'b11
    } cfg_act_e;

    function automatic int cfg_len(input int n_in, input int n_term, input int n_out);
        return n_term * 2 * n_in + n_out * n_term;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain
    import pla_pkg::*;
#(
    parameter int LEN = 66
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           bit_in,
    input  logic           load,
    output logic [LEN-1:0] active_q
);

    logic [LEN-1:0] shadow_q, shadow_d, active_d;
    cfg_act_e       act;

    assign act = cfg_act_e'({load, shift_en});

    // Next-state decode. A load always captures the pre-edge shadow.
    always_comb begin
        shadow_d = shadow_q;
        active_d = active_q;
        unique case (act)
            ACT_IDLE: ;
            ACT_SHIFT: shadow_d = {shadow_q[LEN-2:0], bit_in};
            ACT_LOAD:  active_d = shadow_q;
            ACT_BOTH: begin
                shadow_d = {shadow_q[LEN-2:0], bit_in};
                active_d = shadow_q;
            end
            default: ;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            shadow_q <= shadow_d;
            active_q <= active_d;
        end
    end

    // R7: serial bit enters at the low end, older bits move up
    p_shift_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (shadow_q[0] == $past(bit_in)) &&
                     (shadow_q[LEN-1:1] == $past(shadow_q[LEN-2:0])));

    // R8: without a load the active planes hold
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active_q));

    // R9: load transfers the shadow chain
    p_load_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active_q == $past(shadow_q)));

    // R10: simultaneous shift and load
    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && load) |=> (active_q == $past(shadow_q)) &&
                               (shadow_q[LEN-1:1] == $past(shadow_q[LEN-2:0])));

    // shadow idle when no shift
    p_shadow_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(shadow_q));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
    parameter int N_IN   = 4,
    parameter int N_TERM = 6,
    localparam int RAILS = 2 * N_IN,
    localparam int BITS  = N_TERM * RAILS
) (
    input  logic [N_IN-1:0]   in_vec,
    input  logic [BITS-1:0]   and_mask,
    output logic [N_TERM-1:0] term
);

    logic [RAILS-1:0] rail;

    // True and inverted rail per input
    for (genvar i = 0; i < N_IN; i++) begin : g_rail
        assign rail[2*i]   = in_vec[i];
        assign rail[2*i+1] = ~in_vec[i];
    end

    // Unselected rails are forced high, so an empty row yields 1
    for (genvar p = 0; p < N_TERM; p++) begin : g_term
        logic [RAILS-1:0] sel;
        assign sel     = and_mask[p*RAILS +: RAILS];
        assign term[p] = &(rail | ~sel);
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 6,
    parameter int N_OUT  = 3,
    localparam int BITS  = N_OUT * N_TERM
) (
    input  logic [N_TERM-1:0] term,
    input  logic [BITS-1:0]   or_mask,
    output logic [N_OUT-1:0]  out_vec
);

    for (genvar m = 0; m < N_OUT; m++) begin : g_out
        assign out_vec[m] = |(term & or_mask[m*N_TERM +: N_TERM]);
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int N_TERM = 6,
    parameter int N_OUT  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift_en,
    input  logic             cfg_bit,
    input  logic             cfg_load,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec
);

    localparam int RAILS    = 2 * N_IN;
    localparam int AND_BITS = N_TERM * RAILS;
    localparam int OR_BITS  = N_OUT * N_TERM;
    localparam int CFG_LEN  = cfg_len(N_IN, N_TERM, N_OUT);

    logic [CFG_LEN-1:0]  active;
    logic [AND_BITS-1:0] and_mask;
    logic [OR_BITS-1:0]  or_mask;
    logic [N_TERM-1:0]   term;

    pla_cfg_chain #(.LEN(CFG_LEN)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .bit_in   (cfg_bit),
        .load     (cfg_load),
        .active_q (active)
    );

    // AND field in the upper bits, OR field in the lower bits
    assign and_mask = active[CFG_LEN-1:OR_BITS];
    assign or_mask  = active[OR_BITS-1:0];

    pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
        .in_vec   (in_vec),
        .and_mask (and_mask),
        .term     (term)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
        .term     (term),
        .or_mask  (or_mask),
        .out_vec  (out_vec)
    );

    // R2: an empty row must read 1
    for (genvar p = 0; p < N_TERM; p++) begin : g_chk_term
        p_empty_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (and_mask[p*RAILS +: RAILS] == '0) |-> term[p]);
        for (genvar i = 0; i < N_IN; i++) begin : g_chk_var
            // R3: contradictory rails force the row low
            p_contra_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (and_mask[p*RAILS + 2*i] && and_mask[p*RAILS + 2*i + 1]) |-> !term[p]);
        end
    end

    // R4: an output with no selected row is 0
    for (genvar m = 0; m < N_OUT; m++) begin : g_chk_out
        p_empty_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (or_mask[m*N_TERM +: N_TERM] == '0) |-> !out_vec[m]);
    end

endmodule

// File: tb/pla_array_test.sv
module pla_array_test;

    localparam int N = 4;
    localparam int P = 6;
    localparam int M = 3;
    localparam int L = P * 2 * N + M * P;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_shift_en = 1'b0;
    logic         cfg_bit = 1'b0;
    logic         cfg_load = 1'b0;
    logic [N-1:0] in_vec = '0;
    logic [M-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [L-1:0] cw;

    always #10 clk = ~clk;

    pla_array #(.N_IN(N), .N_TERM(P), .N_OUT(M)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
        .cfg_load(cfg_load), .in_vec(in_vec), .out_vec(out_vec)
    );

    // Expected outputs from the layout stated in R7
    function automatic logic [M-1:0] model(logic [L-1:0] c, logic [N-1:0] x);
        logic [P-1:0] t;
        logic [M-1:0] o;
        for (int p = 0; p < P; p++) begin
            t[p] = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (c[M*P + p*2*N + 2*i]     && !x[i]) t[p] = 1'b0;
                if (c[M*P + p*2*N + 2*i + 1] &&  x[i]) t[p] = 1'b0;
            end
        end
        for (int m = 0; m < M; m++) o[m] = |(t & c[m*P +: P]);
        return o;
    endfunction

    task automatic set_and(int p, int r);
        cw[M*P + p*2*N + r] = 1'b1;
    endtask

    task automatic set_or(int m, int p);
        cw[m*P + p] = 1'b1;
    endtask

    task automatic shift_word(logic [L-1:0] c);
        for (int k = L - 1; k >= 0; k--) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_bit = c[k];
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
    endtask

    task automatic load_pulse();
        @(negedge clk);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic check(logic [N-1:0] x, logic [M-1:0] exp, string tag);
        @(negedge clk);
        in_vec = x;
        #2;
        checks++;
        if (out_vec !== exp) begin
            errors++;
            $display("FAIL %s in=%b out=%b expected=%b", tag, x, out_vec, exp);
        end
    endtask

    logic [95:0] rnd;
    logic [L-1:0] cfg_a, cfg_b, cfg_c;

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R11: reset state
        check(4'hF, 3'b000, "R11 reset");
        rst_n = 1'b1;
        load_pulse();
        check(4'h5, 3'b000, "R11 load after reset");
        check(4'hA, 3'b000, "R4 no rows selected");

        // R6, R5: AB + AC, and row 0 shared to out1 and out2
        cw = '0;
        set_and(0, 0); set_and(0, 2);
        set_and(1, 0); set_and(1, 4);
        set_or(0, 0); set_or(0, 1);
        set_or(1, 0); set_or(2, 0);
        shift_word(cw);
        load_pulse();
        for (int v = 0; v < 16; v++) begin
            logic a, b, c2;
            a = v[0]; b = v[1]; c2 = v[2];
            check(v[3:0], {a & b, a & b, (a & b) | (a & c2)}, "R6/R5 AB+AC shared");
        end

        // R1, R2, R3: empty row, contradictory row, inverted rail
        cw = '0;
        set_and(1, 0); set_and(1, 1);
        set_and(2, 7);
        set_or(0, 0); set_or(1, 1); set_or(2, 2);
        shift_word(cw);
        load_pulse();
        for (int v = 0; v < 16; v++) begin
            check(v[3:0], {~v[3], 1'b0, 1'b1}, "R1/R2/R3 rails");
        end

        // R12: output follows input with no clock edge
        @(negedge clk);
        in_vec = 4'h0;
        #1;
        in_vec = 4'h8;
        #1;
        checks++;
        if (out_vec !== 3'b001) begin
            errors++;
            $display("FAIL R12 out=%b expected=%b", out_vec, 3'b001);
        end

        // Random configurations against the model (R2, R4, R7, R9)
        for (int n = 0; n < 20; n++) begin
            rnd = {$urandom(), $urandom(), $urandom()};
            cfg_a = rnd[L-1:0];
            shift_word(cfg_a);
            load_pulse();
            for (int k = 0; k < 8; k++) begin
                logic [N-1:0] x;
                x = N'($urandom());
                check(x, model(cfg_a, x), "R9/R7 random config");
            end
        end

        // R8: shift a new word without load, outputs keep old config
        rnd = {$urandom(), $urandom(), $urandom()};
        cfg_b = rnd[L-1:0];
        shift_word(cfg_b);
        for (int v = 0; v < 16; v++) begin
            check(v[3:0], model(cfg_a, v[3:0]), "R8 shift without load");
        end

        // R10: shift and load in the same cycle
        @(negedge clk);
        cfg_shift_en = 1'b1;
        cfg_bit = 1'b1;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_shift_en = 1'b0;
        cfg_load = 1'b0;
        for (int v = 0; v < 16; v++) begin
            check(v[3:0], model(cfg_b, v[3:0]), "R10 load takes pre-shift shadow");
        end
        cfg_c = {cfg_b[L-2:0], 1'b1};
        load_pulse();
        for (int v = 0; v < 16; v++) begin
            check(v[3:0], model(cfg_c, v[3:0]), "R10 shift also applied");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule